// File: doc/BRIEF.md
# Path ORAM Access Controller

This block is a compact on-chip oblivious-memory engine. Logical blocks sit in a binary tree of buckets held in internal registers. Every bucket holds a fixed number of slots, and each slot carries a valid flag, the logical address, the assigned leaf label and one data word. A requester presents a read or a write for a logical address through a valid/ready handshake. The block then looks up the address's current leaf in a position map. It walks every bucket from the root down to that leaf and moves the real blocks it finds into an on-chip stash. It serves or overwrites the requested block and gives that block a fresh pseudo-random leaf. Finally it walks the same path back up, from the leaf to the root, emptying the stash greedily into any bucket whose subtree contains each block's leaf. Unused slots are written as dummies.

Every access runs the same number of cycles and touches a full path. The visible pattern therefore says nothing about which address was requested or whether it had been seen before. A logical block that has never been touched reads as zero and is created in the stash on first use. The stash has a fixed size. If it ever runs out of room, the block raises a sticky overflow flag and stops accepting work until reset.

The controller is one state machine with these states:
- ST_IDLE: waits for a request.
- ST_READ: pulls one path slot into the stash per cycle, from the root level to the leaf level.
- ST_UPDATE: serves the requested block and remaps it.
- ST_WRITE: writes one path slot per cycle, from the leaf level to the root level.
- ST_RESP: presents the one-cycle response.
- ST_HALT: the terminal overflow state.

The transitions are:
- ST_IDLE to ST_READ on an accepted request.
- ST_READ to ST_UPDATE after the last slot of the leaf bucket.
- ST_UPDATE to ST_WRITE.
- ST_WRITE to ST_RESP after the last slot of the root bucket.
- ST_RESP to ST_IDLE.
- ST_READ or ST_UPDATE to ST_HALT when a block needs a stash entry and none is free.

Top module: `oram_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and overflow is 0.
- R2: A read returns the data most recently written to that address. A write stores req_wdata and its response returns the value the address held before that write.
- R3: An address that has never been written reads as zero, and that read does not disturb later accesses.
- R4: resp_valid rises exactly 2·(TREE_DEPTH+1)·BUCKET_Z+1 clock edges after the edge that accepted the request (33 with default parameters). It stays high for one cycle only.
- R5: req_ready is 0 from the edge that accepts a request through the response cycle. It is 1 again in the cycle after the response.
- R6: Each access gives the requested block a new leaf, taken from a 16-bit maximal-length LFSR that never holds zero. Repeated accesses to one address keep returning its current value across remaps.
- R7: If a block needs a stash entry and none is free, overflow goes to 1 and stays 1. After that, req_ready stays 0 and no response is produced, whatever req_valid does.
- R8: Every real block read from a bucket lies on the path of its own leaf. As a result, all addresses keep their data across long mixed access sequences over the whole address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical block address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DATA_W | Block value before this access |
| overflow | output | 1 | Sticky stash overflow flag |

## Verification
On every cycle, the assertions check four things. First, any real block fetched from a bucket shares that bucket's path prefix. Second, the requested block sits in the stash with its new leaf as write-back begins. Third, the LFSR never reaches zero. Fourth, overflow stays set and keeps the request side closed, and the busy and response-pulse timing holds.

Only the bench scenarios can show that data actually survives many remaps and evictions across the whole address space. The same applies to reads of untouched addresses returning zero, write responses returning the old value, and a deliberately tiny configuration that truly runs out of stash.

// File: rtl/oram_pkg.sv
package oram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_UPDATE,
        ST_WRITE,
        ST_RESP,
        ST_HALT
    } oram_state_e;
endpackage

// File: rtl/oram_lfsr.sv
module oram_lfsr #(
    parameter int          LEAF_W = 3,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LEAF_W-1:0] leaf
);
    logic [15:0] q;
    logic        fb;

    // x^16 + x^14 + x^13 + x^11 + 1
    assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= SEED;
        else if (step) q <= {q[14:0], fb};
    end

    assign leaf = q[LEAF_W-1:0];

    p_lfsr_live_r6: assert property (@(posedge clk) disable iff (!rst_n) q != 16'h0)
        else $error("LFSR reached zero");
endmodule

// File: rtl/oram_posmap.sv
module oram_posmap #(
    parameter int ADDR_W = 4,
    parameter int LEAF_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LEAF_W-1:0] rleaf,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LEAF_W-1:0] wleaf
);
    localparam int ENTRIES = 2 ** ADDR_W;

    logic [LEAF_W-1:0] map_q [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) map_q[i] <= '0;
        end else if (we) begin
            map_q[waddr] <= wleaf;
        end
    end

    assign rleaf = map_q[raddr];
endmodule

// File: rtl/oram_bucket_store.sv
module oram_bucket_store #(
    parameter int LEVELS   = 4,
    parameter int BUCKET_Z = 4,
    parameter int ADDR_W   = 4,
    parameter int LEAF_W   = 3,
    parameter int DATA_W   = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [$clog2((2**LEVELS)*BUCKET_Z)-1:0]   rd_idx,
    output logic                                      rd_valid,
    output logic [ADDR_W-1:0]                         rd_addr,
    output logic [LEAF_W-1:0]                         rd_leaf,
    output logic [DATA_W-1:0]                         rd_data,
    input  logic                                      we,
    input  logic [$clog2((2**LEVELS)*BUCKET_Z)-1:0]   wr_idx,
    input  logic                                      wr_valid,
    input  logic [ADDR_W-1:0]                         wr_addr,
    input  logic [LEAF_W-1:0]                         wr_leaf,
    input  logic [DATA_W-1:0]                         wr_data
);
    localparam int SLOTS = (2 ** LEVELS) * BUCKET_Z;

    logic              v_q [SLOTS];
    logic [ADDR_W-1:0] a_q [SLOTS];
    logic [LEAF_W-1:0] l_q [SLOTS];
    logic [DATA_W-1:0] d_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                v_q[i] <= 1'b0;
                a_q[i] <= '0;
                l_q[i] <= '0;
                d_q[i] <= '0;
            end
        end else if (we) begin
            v_q[wr_idx] <= wr_valid;
            a_q[wr_idx] <= wr_addr;
            l_q[wr_idx] <= wr_leaf;
            d_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = v_q[rd_idx];
    assign rd_addr  = a_q[rd_idx];
    assign rd_leaf  = l_q[rd_idx];
    assign rd_data  = d_q[rd_idx];
endmodule

// File: rtl/oram_ctrl.sv
module oram_ctrl
    import oram_pkg::*;
#(
    parameter int TREE_DEPTH = 3,
    parameter int BUCKET_Z   = 4,
    parameter int STASH_N    = 16,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              overflow
);
    localparam int LEVELS = TREE_DEPTH + 1;
    localparam int LW     = TREE_DEPTH;
    localparam int SLOT_W = $clog2((2 ** LEVELS) * BUCKET_Z);
    localparam int ZW     = (BUCKET_Z > 1) ? $clog2(BUCKET_Z) : 1;
    localparam int LVW    = $clog2(LEVELS + 1);
    localparam int SW     = (STASH_N > 1) ? $clog2(STASH_N) : 1;

    oram_state_e state_q, state_d;

    logic              op_wr_q, ovf_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [LW-1:0]     leaf_q, nleaf_q;
    logic [LVW-1:0]    lvl_q;
    logic [ZW-1:0]     slot_q;

    logic              st_v [STASH_N];
    logic [ADDR_W-1:0] st_a [STASH_N];
    logic [LW-1:0]     st_l [STASH_N];
    logic [DATA_W-1:0] st_d [STASH_N];

    logic [LW-1:0]     pm_leaf, rnd_leaf;
    logic              accept;
    logic [SLOT_W-1:0] slot_idx;
    logic              t_rd_valid;
    logic [ADDR_W-1:0] t_rd_addr;
    logic [LW-1:0]     t_rd_leaf;
    logic [DATA_W-1:0] t_rd_data;

    logic              free_hit, match_hit, cand_hit;
    logic [SW-1:0]     free_idx, match_idx, cand_idx;
    logic              slot_last;

    function automatic logic [LW-1:0] pfx(input logic [LW-1:0] lf, input logic [LVW-1:0] lv);
        return lf >> (LW - int'(lv));
    endfunction

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign slot_last = (slot_q == ZW'(BUCKET_Z - 1));

    // heap-ordered bucket index of the current path level, root is node 1
    always_comb begin
        int node;
        node     = (1 << int'(lvl_q)) | int'(pfx(leaf_q, lvl_q));
        slot_idx = SLOT_W'(node * BUCKET_Z + int'(slot_q));
    end

    oram_lfsr #(.LEAF_W(LW)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .step(accept), .leaf(rnd_leaf)
    );

    oram_posmap #(.ADDR_W(ADDR_W), .LEAF_W(LW)) u_posmap (
        .clk(clk), .rst_n(rst_n), .raddr(req_addr), .rleaf(pm_leaf),
        .we(accept), .waddr(req_addr), .wleaf(rnd_leaf)
    );

    oram_bucket_store #(
        .LEVELS(LEVELS), .BUCKET_Z(BUCKET_Z), .ADDR_W(ADDR_W),
        .LEAF_W(LW), .DATA_W(DATA_W)
    ) u_tree (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(slot_idx), .rd_valid(t_rd_valid), .rd_addr(t_rd_addr),
        .rd_leaf(t_rd_leaf), .rd_data(t_rd_data),
        .we(state_q == ST_WRITE), .wr_idx(slot_idx), .wr_valid(cand_hit),
        .wr_addr(st_a[cand_idx]), .wr_leaf(st_l[cand_idx]), .wr_data(st_d[cand_idx])
    );

    // stash searches; lowest index wins
    always_comb begin
        free_hit = 1'b0;  free_idx  = '0;
        match_hit = 1'b0; match_idx = '0;
        cand_hit = 1'b0;  cand_idx  = '0;
        for (int i = STASH_N - 1; i >= 0; i--) begin
            if (!st_v[i]) begin
                free_hit = 1'b1; free_idx = SW'(i);
            end
            if (st_v[i] && st_a[i] == addr_q) begin
                match_hit = 1'b1; match_idx = SW'(i);
            end
            if (st_v[i] && pfx(st_l[i], lvl_q) == pfx(leaf_q, lvl_q)) begin
                cand_hit = 1'b1; cand_idx = SW'(i);
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_READ;
            ST_READ: begin
                if (t_rd_valid && !free_hit)
                    state_d = ST_HALT;
                else if (slot_last && lvl_q == LVW'(TREE_DEPTH))
                    state_d = ST_UPDATE;
            end
            ST_UPDATE: state_d = (match_hit || free_hit) ? ST_WRITE : ST_HALT;
            ST_WRITE:  if (slot_last && lvl_q == '0) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and stash
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0; ovf_q <= 1'b0;
            addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
            leaf_q <= '0; nleaf_q <= '0; lvl_q <= '0; slot_q <= '0;
            for (int i = 0; i < STASH_N; i++) begin
                st_v[i] <= 1'b0; st_a[i] <= '0; st_l[i] <= '0; st_d[i] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_wr_q <= req_write;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    leaf_q  <= pm_leaf;
                    nleaf_q <= rnd_leaf;
                    lvl_q   <= '0;
                    slot_q  <= '0;
                end
                ST_READ: begin
                    if (t_rd_valid) begin
                        if (free_hit) begin
                            st_v[free_idx] <= 1'b1;
                            st_a[free_idx] <= t_rd_addr;
                            st_l[free_idx] <= t_rd_leaf;
                            st_d[free_idx] <= t_rd_data;
                        end else begin
                            ovf_q <= 1'b1;
                        end
                    end
                    if (slot_last) begin
                        slot_q <= '0;
                        lvl_q  <= lvl_q + 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                ST_UPDATE: begin
                    lvl_q  <= LVW'(TREE_DEPTH);
                    slot_q <= '0;
                    if (match_hit) begin
                        rdata_q <= st_d[match_idx];
                        st_l[match_idx] <= nleaf_q;
                        if (op_wr_q) st_d[match_idx] <= wdata_q;
                    end else if (free_hit) begin
                        rdata_q <= '0;
                        st_v[free_idx] <= 1'b1;
                        st_a[free_idx] <= addr_q;
                        st_l[free_idx] <= nleaf_q;
                        st_d[free_idx] <= op_wr_q ? wdata_q : '0;
                    end else begin
                        ovf_q <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (cand_hit) st_v[cand_idx] <= 1'b0;
                    if (slot_last) begin
                        slot_q <= '0;
                        lvl_q  <= lvl_q - 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_RESP);
        resp_rdata = rdata_q;
        overflow   = ovf_q;
    end

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow)
        else $error("overflow flag cleared");
    p_ovf_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n) overflow |-> (!req_ready && !resp_valid))
        else $error("activity after overflow");
    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready)
        else $error("ready while busy");
    p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) resp_valid |=> (!resp_valid && req_ready))
        else $error("response longer than one cycle");
    p_path_prefix_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && t_rd_valid) |-> pfx(t_rd_leaf, lvl_q) == pfx(leaf_q, lvl_q))
        else $error("block found off its path");
    p_block_remapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE && (match_hit || free_hit)) |=>
        (match_hit && st_l[match_idx] == nleaf_q && (!op_wr_q || st_d[match_idx] == wdata_q)))
        else $error("requested block not remapped in stash");
endmodule

// File: tb/sim_oram_ctrl.sv
module sim_oram_ctrl;
    localparam int DW = 16;
    localparam int LAT = 2 * (3 + 1) * 4 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]    req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, resp_valid, overflow;
    logic [DW-1:0] resp_rdata;

    oram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .overflow(overflow)
    );

    logic          b_valid = 1'b0;
    logic [2:0]    b_addr = '0;
    logic [DW-1:0] b_wdata = '0;
    logic          b_ready, b_resp, b_ovf;
    logic [DW-1:0] b_rdata;

    oram_ctrl #(.TREE_DEPTH(1), .BUCKET_Z(1), .STASH_N(1), .ADDR_W(3), .DATA_W(DW)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
        .req_write(1'b1), .req_addr(b_addr), .req_wdata(b_wdata),
        .resp_valid(b_resp), .resp_rdata(b_rdata), .overflow(b_ovf)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int model [16];
    int q_exp [$];
    int q_acc [$];
    string q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic access(input bit wr, input int addr, input int data, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 4'(addr); req_wdata = DW'(data);
        @(negedge clk);
        req_valid = 1'b0;
        q_exp.push_back(model[addr]);
        q_acc.push_back(cyc);
        q_tag.push_back(tag);
        if (wr) model[addr] = data & 16'hFFFF;
        check(req_ready == 1'b0, "R5 busy after accept", int'(req_ready), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (q_exp.size() == 0) begin
                check(1'b0, "R4 unexpected response", 1, 0);
            end else begin
                int e, a;
                string t;
                e = q_exp.pop_front();
                a = q_acc.pop_front();
                t = q_tag.pop_front();
                check(int'(resp_rdata) == e, t, int'(resp_rdata), e);
                check(cyc - a == LAT, "R4 latency", cyc - a, LAT);
                check(req_ready == 1'b0, "R5 ready low in response cycle", int'(req_ready), 0);
            end
        end
    end

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned seed;
        bit got;
        for (int i = 0; i < 16; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
        check(resp_valid == 1'b0, "R1 resp in reset", int'(resp_valid), 0);
        check(overflow == 1'b0, "R1 overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && b_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        // R3: untouched address reads zero
        access(1'b0, 3, 0, "R3 untouched read");
        access(1'b0, 9, 0, "R3 second untouched read");
        // R2: write returns old, read returns new
        access(1'b1, 3, 16'h1234, "R2 write returns old");
        access(1'b0, 3, 0, "R2 read back");
        access(1'b1, 3, 16'hBEEF, "R2 overwrite returns previous");
        access(1'b0, 3, 0, "R2 read overwritten");
        // R8: whole address space
        for (int i = 0; i < 16; i++) access(1'b1, i, 16'h0A00 + i * 7, "R8 fill");
        for (int i = 15; i >= 0; i--) access(1'b0, i, 0, "R8 read all");
        // R6: hammer one address across many remaps
        for (int i = 0; i < 24; i++) access(i[0], 5, 16'h5000 + i, "R6 repeated remap");
        // R8: pseudo-random mix
        seed = 32'h1F2E3D4C;
        for (int i = 0; i < 200; i++) begin
            seed = seed * 1103515245 + 12345;
            access(seed[20], int'(seed[27:24]), int'(seed[15:0]), "R8 mixed");
        end
        while (q_exp.size() != 0) @(negedge clk);
        @(negedge clk);
        check(req_ready == 1'b1 && overflow == 1'b0, "R5 ready after response", int'(req_ready), 1);

        // R7: tiny instance must run out of stash
        got = 1'b0;
        for (int k = 0; k < 6 && !b_ovf; k++) begin
            int w;
            @(negedge clk);
            if (!b_ready) break;
            b_valid = 1'b1; b_addr = 3'(k); b_wdata = DW'(16'h7700 + k);
            @(negedge clk);
            b_valid = 1'b0;
            w = 0;
            while (!b_resp && !b_ovf && w < 50) begin @(negedge clk); w++; end
            if (k == 0) begin
                check(b_ovf == 1'b0, "R7 no overflow on first write", int'(b_ovf), 0);
                check(b_resp == 1'b1, "R7 first write answered", int'(b_resp), 1);
                check(int'(b_rdata) == 0, "R3 tiny first write old value", int'(b_rdata), 0);
            end
        end
        check(b_ovf == 1'b1, "R7 overflow raised", int'(b_ovf), 1);
        b_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(b_ready == 1'b0, "R7 ready stays low", int'(b_ready), 0);
            check(b_resp == 1'b0 && b_ovf == 1'b1, "R7 no response, flag held", int'(b_resp), 0);
        end
        b_valid = 1'b0;
        summary();
    end
endmodule